// File: doc/BRIEF.md
# AC97 Link Frame Controller

The block is the controller end of a five-wire AC97 link. The codec supplies the serial bit clock, and the whole block runs on it. From that clock the controller produces the frame sync. Each frame has 13 time slots and travels in both directions at once. One serial output line carries playback data and one serial input line returns capture data. The controller also drives the active-low reset of the codec. It releases that reset with a fixed sequence after its own reset is removed.

On the parallel side, the transmit side offers one 16-bit tag word and twelve 20-bit slot words. The controller takes a copy of them when a frame begins and shifts them out MSB first. The receive side collects the same 256-bit layout from the input line. After the last bit of a frame arrives, it presents the tag and the twelve slots together with a one-cycle strobe. Register access, rate conversion and data movement are left to logic around the block.

Top module: `ac97_link_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sync_o`, `sdata_o`, `link_rst_no` and `rx_valid_o` are all low, and asserting `rst_ni` forces them low without waiting for a clock edge.
- R2: After `rst_ni` rises, `link_rst_no` stays low for `RST_CYC` rising bit-clock edges and goes high at edge number `RST_CYC`; it then stays high until the next reset.
- R3: The first frame starts at rising edge number `RST_CYC + WAIT_CYC` after `rst_ni` rises; `sync_o` stays low before that edge.
- R4: A frame is 256 bit clocks. `sync_o` is high for the first 16 bit clocks of each frame and low for the other 240, and frames follow one another with no gap.
- R5: Within a frame, `sdata_o` carries the tag first, then slot 1 through slot 12, each MSB first, with bits changing on the rising bit-clock edge. Slot k is `tx_slot_i[(k-1)*20 +: 20]`.
- R6: The tag and slot inputs are latched at the start of each frame. Changing them during a frame does not alter the bits of that frame.
- R7: `sdata_i` is sampled on the falling bit-clock edge using the same layout as R5. The 16 first bits go to `rx_tag_o`, and slot k goes to `rx_slot_o[(k-1)*20 +: 20]`.
- R8: `rx_valid_o` is high for exactly one bit clock per received frame. That cycle is the one after the frame's last bit, which is the first bit of the next frame, and the received words are valid in it.
- R9: A reset that arrives in the middle of a frame abandons that frame. Once released, the R2 and R3 sequence runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Serial bit clock from the codec |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial capture data from the codec |
| sync_o | output | 1 | Frame sync to the codec |
| sdata_o | output | 1 | Serial playback data to the codec |
| link_rst_no | output | 1 | Active-low reset to the codec |
| tx_tag_i | input | 16 | Tag word for transmit |
| tx_slot_i | input | 240 | Transmit slots 1 to 12, slot k at bits (k-1)*20 upward |
| rx_tag_o | output | 16 | Received tag word |
| rx_slot_o | output | 240 | Received slots 1 to 12, same packing as transmit |
| rx_valid_o | output | 1 | One-cycle strobe when a received frame is complete |

## Verification
The hardest case to reach is the mid-frame change of the transmit words, because the serial output of the current frame must not move. The bench aligns itself to a sync rising edge and then counts falling edges to stay in step with each bit. Partway through a frame it inverts every transmit input and compares all 256 serial bits with the words latched earlier. It drives capture bits one falling edge ahead in the same way, so that every received bit position holds a known value. It also asserts reset while a frame is in flight and checks that the release sequence starts again.

// File: rtl/ac97_link_pkg.sv
package ac97_link_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int N_SLOTS    = 12;
  localparam int FRAME_BITS = TAG_W + N_SLOTS * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    PH_RST  = 2'd0,
    PH_WAIT = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;
endpackage

// File: rtl/ac97_link_seq.sv
module ac97_link_seq
  import ac97_link_pkg::*;
#(
  parameter int RST_CYC  = 8,
  parameter int WAIT_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             link_rst_no,
  output logic             run_o,
  output logic             load_o,
  output logic             last_o,
  output logic             sync_o
);
  localparam int TMAX = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  phase_e           phase_q;
  logic [TW-1:0]    tmr_q;
  logic [CNT_W-1:0] bit_q;

  assign run_o       = (phase_q == PH_RUN);
  assign link_rst_no = (phase_q != PH_RST);
  assign last_o      = run_o && (bit_q == CNT_W'(FRAME_BITS - 1));
  assign sync_o      = run_o && (bit_q < CNT_W'(TAG_W));
  // frame words are captured on the edge that starts a frame
  assign load_o      = ((phase_q == PH_WAIT) && (tmr_q == TW'(WAIT_CYC - 1))) || last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RST;
      tmr_q   <= '0;
      bit_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_RST: begin
          if (tmr_q == TW'(RST_CYC - 1)) begin
            phase_q <= PH_WAIT;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        PH_WAIT: begin
          if (tmr_q == TW'(WAIT_CYC - 1)) begin
            phase_q <= PH_RUN;
            bit_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: begin
          bit_q <= last_o ? '0 : bit_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ac97_link_tx.sv
module ac97_link_tx
  import ac97_link_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      run_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic [N_SLOTS*SLOT_W-1:0] slot_i,
  output logic                      sdata_o
);
  logic [FRAME_BITS-1:0] word;
  logic [FRAME_BITS-1:0] sh_q;

  assign word[FRAME_BITS-1 -: TAG_W] = tag_i;
  for (genvar k = 0; k < N_SLOTS; k++) begin : g_pack
    assign word[FRAME_BITS-TAG_W-k*SLOT_W-1 -: SLOT_W] = slot_i[k*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= word;
    else if (run_i)  sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
  end

  assign sdata_o = run_i & sh_q[FRAME_BITS-1];
endmodule

// File: rtl/ac97_link_rx.sv
module ac97_link_rx
  import ac97_link_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      run_i,
  input  logic                      last_i,
  input  logic                      sdata_i,
  output logic [TAG_W-1:0]          tag_o,
  output logic [N_SLOTS*SLOT_W-1:0] slot_o,
  output logic                      valid_o
);
  logic [FRAME_BITS-1:0]     sh_q;
  logic [N_SLOTS*SLOT_W-1:0] slot_d;

  // capture on falling edge, half a bit after the codec launches
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (run_i) sh_q <= {sh_q[FRAME_BITS-2:0], sdata_i};
  end

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_unpack
    assign slot_d[k*SLOT_W +: SLOT_W] = sh_q[FRAME_BITS-TAG_W-k*SLOT_W-1 -: SLOT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o   <= '0;
      slot_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= last_i;
      if (last_i) begin
        tag_o  <= sh_q[FRAME_BITS-1 -: TAG_W];
        slot_o <= slot_d;
      end
    end
  end
endmodule

// File: rtl/ac97_link_ctrl.sv
module ac97_link_ctrl
  import ac97_link_pkg::*;
#(
  parameter int RST_CYC  = 8,
  parameter int WAIT_CYC = 4
) (
  input  logic                      bit_clk_i,
  input  logic                      rst_ni,
  input  logic                      sdata_i,
  output logic                      sync_o,
  output logic                      sdata_o,
  output logic                      link_rst_no,
  input  logic [TAG_W-1:0]          tx_tag_i,
  input  logic [N_SLOTS*SLOT_W-1:0] tx_slot_i,
  output logic [TAG_W-1:0]          rx_tag_o,
  output logic [N_SLOTS*SLOT_W-1:0] rx_slot_o,
  output logic                      rx_valid_o
);
  logic run, load, last;

  ac97_link_seq #(.RST_CYC(RST_CYC), .WAIT_CYC(WAIT_CYC)) u_seq (
    .clk_i       (bit_clk_i),
    .rst_ni      (rst_ni),
    .link_rst_no (link_rst_no),
    .run_o       (run),
    .load_o      (load),
    .last_o      (last),
    .sync_o      (sync_o)
  );

  ac97_link_tx u_tx (
    .clk_i   (bit_clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .run_i   (run),
    .tag_i   (tx_tag_i),
    .slot_i  (tx_slot_i),
    .sdata_o (sdata_o)
  );

  ac97_link_rx u_rx (
    .clk_i   (bit_clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .last_i  (last),
    .sdata_i (sdata_i),
    .tag_o   (rx_tag_o),
    .slot_o  (rx_slot_o),
    .valid_o (rx_valid_o)
  );
endmodule

// File: rtl/ac97_link_chk.sv
module ac97_link_chk
  import ac97_link_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic sync_i,
  input logic sdata_i,
  input logic link_rst_ni,
  input logic rx_valid_i
);
  logic             prev_q, seen_q;
  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      prev_q <= sync_i;
      if (sync_i && !prev_q) begin
        seen_q <= 1'b1;
        idx_q  <= CNT_W'(1);
      end else if (seen_q) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R1
  codec_rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_rst_ni |-> (!sync_i && !sdata_i && !rx_valid_i));

  // R2
  codec_rst_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rst_ni |=> link_rst_ni);

  // R4
  sync_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (sync_i == (idx_q < CNT_W'(TAG_W))));

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i);

  // R8
  valid_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |-> (sync_i && !prev_q));
endmodule

bind ac97_link_ctrl ac97_link_chk u_chk (
  .clk_i       (bit_clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_o),
  .sdata_i     (sdata_o),
  .link_rst_ni (link_rst_no),
  .rx_valid_i  (rx_valid_o)
);

// File: tb/ac97_link_ctrl_test.sv
module ac97_link_ctrl_test;
  import ac97_link_pkg::*;

  localparam int RST_CYC  = 8;
  localparam int WAIT_CYC = 4;
  localparam int SW       = N_SLOTS * SLOT_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              sdata_i = 1'b0;
  logic              sync_o, sdata_o, link_rst_no, rx_valid_o;
  logic [TAG_W-1:0]  tx_tag_i = '0;
  logic [SW-1:0]     tx_slot_i = '0;
  logic [TAG_W-1:0]  rx_tag_o;
  logic [SW-1:0]     rx_slot_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ac97_link_ctrl #(.RST_CYC(RST_CYC), .WAIT_CYC(WAIT_CYC)) uut (
    .bit_clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata_i),
    .sync_o(sync_o), .sdata_o(sdata_o), .link_rst_no(link_rst_no),
    .tx_tag_i(tx_tag_i), .tx_slot_i(tx_slot_i),
    .rx_tag_o(rx_tag_o), .rx_slot_o(rx_slot_o), .rx_valid_o(rx_valid_o)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [FRAME_BITS-1:0] act, input logic [FRAME_BITS-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FRAME_BITS-1:0] pack_frame(logic [TAG_W-1:0] t, logic [SW-1:0] s);
    logic [FRAME_BITS-1:0] v;
    v[FRAME_BITS-1 -: TAG_W] = t;
    for (int k = 0; k < N_SLOTS; k++)
      v[FRAME_BITS-TAG_W-k*SLOT_W-1 -: SLOT_W] = s[k*SLOT_W +: SLOT_W];
    return v;
  endfunction

  function automatic logic [SW-1:0] gen_slots(int seed);
    logic [SW-1:0] s;
    for (int k = 0; k < N_SLOTS; k++)
      s[k*SLOT_W +: SLOT_W] = SLOT_W'((seed * (k + 7) * 40503) ^ (k << 15) ^ (seed << 3));
    return s;
  endfunction

  // R1, R2, R3: reset, codec reset release and first sync
  task automatic t_reset_seq();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk({sync_o, sdata_o, link_rst_no, rx_valid_o} == 4'b0, "R1 outputs in reset",
        FRAME_BITS'({sync_o, sdata_o, link_rst_no, rx_valid_o}), '0);
    rst_ni = 1'b1;
    for (int k = 1; k <= RST_CYC + WAIT_CYC; k++) begin
      @(negedge clk);
      if (k == RST_CYC - 1) chk(!link_rst_no, "R2 codec reset still low", FRAME_BITS'(link_rst_no), '0);
      if (k == RST_CYC)     chk(link_rst_no, "R2 codec reset released", FRAME_BITS'(link_rst_no), 1);
      if (k == RST_CYC + WAIT_CYC - 1) chk(!sync_o, "R3 no sync before start", FRAME_BITS'(sync_o), '0);
      if (k == RST_CYC + WAIT_CYC) begin
        chk(sync_o, "R3 first sync", FRAME_BITS'(sync_o), 1);
        chk(sdata_o == tx_tag_i[TAG_W-1], "R5 first bit", FRAME_BITS'(sdata_o),
            FRAME_BITS'(tx_tag_i[TAG_W-1]));
      end
    end
  endtask

  // R4, R5, R6, R7, R8: one full frame both directions
  task automatic t_frame(input logic [TAG_W-1:0] t, input logic [SW-1:0] s,
                         input logic [FRAME_BITS-1:0] rxv, input bit corrupt);
    logic [FRAME_BITS-1:0] got, exp, rxexp;
    logic prv;
    bit sync_ok = 1, val_ok = 1;
    prv = sync_o;
    forever begin
      @(negedge clk);
      if (sync_o && !prv) break;
      prv = sync_o;
    end
    repeat (FRAME_BITS - 1) @(negedge clk);
    #1;
    sdata_i   = rxv[FRAME_BITS-1];
    tx_tag_i  = t;
    tx_slot_i = s;
    exp = pack_frame(t, s);
    for (int i = 0; i < FRAME_BITS; i++) begin
      @(negedge clk);
      got[FRAME_BITS-1-i] = sdata_o;
      if (sync_o != (i < TAG_W)) sync_ok = 0;
      if (rx_valid_o != (i == 0)) val_ok = 0;
      #1;
      if (i < FRAME_BITS - 1) sdata_i = rxv[FRAME_BITS-2-i];
      if (corrupt && i == 100) begin
        tx_tag_i  = ~t;
        tx_slot_i = ~s;
      end
    end
    chk(got == exp, corrupt ? "R6 latched frame" : "R5 serial order", got, exp);
    chk(sync_ok, "R4 sync width", FRAME_BITS'(sync_ok), 1);
    chk(val_ok, "R8 strobe only at frame start", FRAME_BITS'(val_ok), 1);
    @(negedge clk);
    chk(rx_valid_o && sync_o, "R8 strobe with next sync", FRAME_BITS'({rx_valid_o, sync_o}), 3);
    rxexp = pack_frame(rx_tag_o, rx_slot_o);
    chk(rxexp == rxv, "R7 received words", rxexp, rxv);
    @(negedge clk);
    chk(!rx_valid_o, "R8 strobe one cycle", FRAME_BITS'(rx_valid_o), '0);
  endtask

  // R9: reset mid-frame
  task automatic t_mid_reset();
    repeat (77) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk({sync_o, sdata_o, link_rst_no, rx_valid_o} == 4'b0, "R9 async abort",
        FRAME_BITS'({sync_o, sdata_o, link_rst_no, rx_valid_o}), '0);
    t_reset_seq();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    tx_tag_i  = 16'h9C31;
    tx_slot_i = gen_slots(1);
    t_reset_seq();
    t_frame(16'hA5C3, gen_slots(2), {8{32'hDEADBEEF}}, 1'b0);
    t_frame(16'hFFFF, '1, '0, 1'b0);
    t_frame(16'h0001, gen_slots(3), {32{8'hA5}}, 1'b1);
    t_frame(16'h8000, '0, '1, 1'b0);
    t_mid_reset();
    t_frame(16'h1234, gen_slots(4), {16{16'h3C96}}, 1'b0);
    finish_run();
  end

  initial begin
    #(8 * 150000);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule